// File: doc/BRIEF.md
# Two-Wire Serial Configuration Memory Slave

This block is the target side of a serial configuration memory on a two-wire bus. The bus has one clock line driven by the master and one open-drain data line. The block samples both lines through synchronizers in its own system clock domain. It finds start and stop conditions and answers to one fixed 7-bit device address. It then takes a three-byte memory address and carries out writes or reads against an on-chip byte array.

Writes stay inside a 128-byte page. A stop that closes a write transaction starts an internally timed write cycle. Until that cycle ends the block ignores the bus, so a master learns that the write is complete by repeating the device address until the block acknowledges it. Reads may start at the current address or at an address the master supplies, and they continue for as long as the master acknowledges. A fixed pair of identification bytes sits at one reserved address and cannot be written.

Top module: `cfgmem_slave`

## Requirements
- R1: The device address byte is 1010011 followed by a direction bit (1 = read, 0 = write), most significant bit first. Any other 7-bit address gets no acknowledge, and the block then waits for the next start.
- R2: After a write-direction device address, three memory address bytes follow, high byte first, each most significant bit first. The block acknowledges each byte by pulling the data line low during the ninth clock.
- R3: Data bytes travel least significant bit first, both from the master on a write and from the block on a read.
- R4: A start condition (data falling while clock is high) returns the block to waiting for a device address, from any state and at any bit position.
- R5: During a write, each data byte goes to the current write address. Only the low 7 address bits then increment, so bytes past the end of a 128-byte page wrap to the first byte of the same page.
- R6: A stop condition (data rising while clock is high) after at least one written data byte starts a write cycle of WR_CYCLES system clocks. During that cycle the block ignores the bus and does not acknowledge its device address. After the cycle it acknowledges again.
- R7: The current address is the last accessed address plus one across the whole array. After a write to the last byte of a page, a current-address read returns the first byte of the next page.
- R8: A read sends bytes from consecutive addresses for as long as the master acknowledges. After the last array address it continues at address 0. A master non-acknowledge ends the read, and the next read at the current address continues after the last byte sent.
- R9: Reading address 0x040000 returns 0x1E, and reading the address after it returns 0xF7. Writes to these two addresses leave them and the array unchanged.
- R10: The block drives the data line only low, through an output enable. The enable is active only in its own acknowledge bits and read data bits, and it is never active after reset or while the block is idle.
- R11: A write transaction that carries only an address and no data bytes does not start a write cycle when it ends with a stop. It does set the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_oe | output | 1 | When high, the pin pulls the data line low |

## Verification
The hardest situation to reach is a device address that arrives while the internal write cycle is still running. Here the block must stay silent even though the byte is valid. The bench shortens the write cycle to a few hundred clocks and sends a start and the device address at once after the stop that closes a write. It then waits out the cycle and polls again, and the same poll must now be acknowledged. The other hard cases are a start in the middle of an address byte and a sequential read that passes the end of the array. Both are driven on purpose: the bench pre-writes the last two array bytes and cuts a byte off after four bits.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_AH,
        ST_AM,
        ST_AL,
        ST_WR,
        ST_ACK,
        ST_RD,
        ST_MACK
    } st_e;

    localparam int ADDR_W = 24;

    // next address in a linear array of 2**aw bytes, wrapping to zero
    function automatic logic [ADDR_W-1:0] array_inc(input logic [ADDR_W-1:0] a,
                                                    input int unsigned aw);
        logic [ADDR_W-1:0] mask;
        mask = (ADDR_W'(1) << aw) - ADDR_W'(1);
        return (a + ADDR_W'(1)) & mask;
    endfunction

    // next address inside the same page of 2**pw bytes
    function automatic logic [ADDR_W-1:0] page_inc(input logic [ADDR_W-1:0] a,
                                                   input int unsigned pw);
        logic [ADDR_W-1:0] mask;
        mask = (ADDR_W'(1) << pw) - ADDR_W'(1);
        return (a & ~mask) | ((a + ADDR_W'(1)) & mask);
    endfunction

endpackage

// File: rtl/cfgmem_busline.sv
module cfgmem_busline (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [1:0] scl_sync, sda_sync;
    logic       scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_d    <= scl_sync[1];
            sda_d    <= sda_sync[1];
        end
    end

    assign scl_s     = scl_sync[1];
    assign sda_s     = sda_sync[1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/cfgmem_array.sv
module cfgmem_array #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [7:0]    wd,
    input  logic [AW-1:0] ra,
    output logic [7:0]    rd
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    assign rd = mem[ra];
endmodule

// File: rtl/cfgmem_wtimer.sv
module cfgmem_wtimer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (go && !busy) begin
            busy <= 1'b1;
            cnt  <= CW'(CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/cfgmem_slave.sv
module cfgmem_slave
    import cfgmem_pkg::*;
#(
    parameter int          MEM_AW    = 10,
    parameter int          PAGE_AW   = 7,
    parameter int          WR_CYCLES = 2000,
    parameter logic [6:0]  DEV_ADDR  = 7'b1010011,
    parameter logic [23:0] ID_ADDR   = 24'h040000,
    parameter logic [7:0]  ID_BYTE0  = 8'h1E,
    parameter logic [7:0]  ID_BYTE1  = 8'hF7
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int HI_W = ADDR_W - 8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic busy, wr_go;

    st_e               st, nxt;
    logic [3:0]        bitcnt;
    logic [7:0]        sh, rbyte;
    logic [HI_W-1:0]   hi_addr;
    logic [ADDR_W-1:0] wp, cur;
    logic              wrote, mack;

    logic              cur_id, wp_id, mem_we;
    logic [7:0]        mem_rd, rd_val;
    logic [ADDR_W-1:0] rd_step, wp_step, wr_cur;

    cfgmem_busline u_line (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    cfgmem_wtimer #(.CYCLES(WR_CYCLES)) u_tmr (
        .clk(clk), .rst(rst), .go(wr_go), .busy(busy)
    );

    cfgmem_array #(.AW(MEM_AW)) u_mem (
        .clk(clk), .rst(rst), .we(mem_we), .wa(wp[MEM_AW-1:0]), .wd(sh),
        .ra(cur[MEM_AW-1:0]), .rd(mem_rd)
    );

    assign cur_id  = (cur[ADDR_W-1:1] == ID_ADDR[ADDR_W-1:1]);
    assign wp_id   = (wp[ADDR_W-1:1]  == ID_ADDR[ADDR_W-1:1]);
    assign rd_val  = cur_id ? (cur[0] ? ID_BYTE1 : ID_BYTE0) : mem_rd;
    assign rd_step = (cur_id && !cur[0]) ? cur + ADDR_W'(1) : array_inc(cur, MEM_AW);
    assign wp_step = page_inc(wp, PAGE_AW);
    assign wr_cur  = array_inc(wp, MEM_AW);

    assign wr_go   = stop_evt && wrote && !busy;
    assign mem_we  = !busy && !start_evt && !stop_evt && (st == ST_WR)
                     && scl_fall && (bitcnt == 4'd8) && !wp_id;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            nxt     <= ST_IDLE;
            bitcnt  <= '0;
            sh      <= '0;
            rbyte   <= '0;
            hi_addr <= '0;
            wp      <= '0;
            cur     <= '0;
            sda_oe  <= 1'b0;
            wrote   <= 1'b0;
            mack    <= 1'b0;
        end else if (busy) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
            wrote  <= 1'b0;
        end else if (start_evt) begin
            st     <= ST_DEV;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (stop_evt) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
            wrote  <= 1'b0;
        end else begin
            case (st)
                ST_DEV, ST_AH, ST_AM, ST_AL, ST_WR: begin
                    if (scl_rise) begin
                        sh     <= (st == ST_WR) ? {sda_s, sh[7:1]} : {sh[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        sda_oe <= 1'b1;
                        st     <= ST_ACK;
                        case (st)
                            ST_DEV: begin
                                if (sh[7:1] != DEV_ADDR) begin
                                    sda_oe <= 1'b0;
                                    st     <= ST_IDLE;
                                end else begin
                                    nxt <= sh[0] ? ST_RD : ST_AH;
                                end
                            end
                            ST_AH: begin
                                hi_addr[HI_W-1:8] <= sh;
                                nxt <= ST_AM;
                            end
                            ST_AM: begin
                                hi_addr[7:0] <= sh;
                                nxt <= ST_AL;
                            end
                            ST_AL: begin
                                wp  <= {hi_addr, sh};
                                cur <= {hi_addr, sh};
                                nxt <= ST_WR;
                            end
                            default: begin
                                wrote <= 1'b1;
                                wp    <= wp_step;
                                cur   <= wr_cur;
                                nxt   <= ST_WR;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (nxt == ST_RD) begin
                            rbyte  <= rd_val;
                            sda_oe <= ~rd_val[0];
                            cur    <= rd_step;
                            st     <= ST_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= nxt;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            st     <= ST_MACK;
                        end else begin
                            sda_oe <= ~rbyte[bitcnt[2:0]];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        bitcnt <= '0;
                        if (mack) begin
                            rbyte  <= rd_val;
                            sda_oe <= ~rd_val[0];
                            cur    <= rd_step;
                            st     <= ST_RD;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfgmem_slave_chk.sv
module cfgmem_slave_chk
    import cfgmem_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic sda_oe,
    input logic busy,
    input logic scl_s,
    input logic start_evt,
    input logic stop_evt,
    input st_e  st
);
    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);

    // R6
    busy_silent_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);

    // R6
    busy_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_evt));

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (start_evt && !busy) |=> (st == ST_DEV));

    // R10
    oe_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);
endmodule

bind cfgmem_slave cfgmem_slave_chk u_chk (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .busy(busy), .scl_s(scl_s),
    .start_evt(start_evt), .stop_evt(stop_evt), .st(st)
);

// File: tb/sim_cfgmem_slave.sv
module sim_cfgmem_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int AW         = 9;
    localparam int DEPTH      = 1 << AW;
    localparam int WRC        = 400;
    localparam int LIMIT      = 190000;
    localparam int IDA        = 'h040000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_low_m = 1'b0;
    logic sda_oe;
    wire  sda_line = ~(sda_low_m | sda_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgmem_slave #(.MEM_AW(AW), .WR_CYCLES(WRC)) u0 (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit may_drive = 1'b0;
    int drive_viol = 0;
    logic [7:0] bm [DEPTH];
    int bcur = 0;

    // R10: on every clock, the enable may only be active in slave-driven bits
    always @(negedge clk) if (!rst && sda_oe && !may_drive) drive_viol++;

    always @(posedge clk) begin
        cyc++;
        if (cyc >= LIMIT && !done) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=<%0d", cyc, LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic m_start();
        sda_low_m = 1'b0; wt(Q);
        scl_m = 1'b1;     wt(Q);
        sda_low_m = 1'b1; wt(Q);
        scl_m = 1'b0;     wt(Q);
    endtask

    task automatic m_stop();
        sda_low_m = 1'b1; wt(Q);
        scl_m = 1'b1;     wt(Q);
        sda_low_m = 1'b0; wt(Q);
    endtask

    task automatic m_wbit(input logic b);
        sda_low_m = ~b; wt(Q);
        scl_m = 1'b1;   wt(2*Q);
        scl_m = 1'b0;   wt(2);
    endtask

    task automatic m_rbit(output logic b);
        may_drive = 1'b1;
        sda_low_m = 1'b0; wt(Q);
        scl_m = 1'b1;     wt(Q);
        b = sda_line;     wt(Q);
        scl_m = 1'b0;     wt(4);
        may_drive = 1'b0;
    endtask

    task automatic wbyte_msb(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) m_wbit(v[i]);
        m_rbit(ack);
    endtask

    task automatic wbyte_lsb(input logic [7:0] v, output logic ack);
        for (int i = 0; i < 8; i++) m_wbit(v[i]);
        m_rbit(ack);
    endtask

    task automatic rbyte_lsb(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 0; i < 8; i++) begin
            m_rbit(b);
            v[i] = b;
        end
        m_wbit(~give_ack);
    endtask

    function automatic logic [7:0] exp_rd(input int a);
        if ((a >> 1) == (IDA >> 1)) return (a % 2) ? 8'hF7 : 8'h1E;
        return bm[a % DEPTH];
    endfunction

    function automatic int nxt_rd(input int a);
        if ((a >> 1) == (IDA >> 1) && (a % 2) == 0) return a + 1;
        return (a + 1) % DEPTH;
    endfunction

    task automatic send_addr(input int addr, inout bit ok);
        logic ack;
        wbyte_msb(8'hA6, ack);                 ok &= (ack == 1'b0);
        wbyte_msb(8'((addr >> 16) & 255), ack); ok &= (ack == 1'b0);
        wbyte_msb(8'((addr >> 8) & 255), ack);  ok &= (ack == 1'b0);
        wbyte_msb(8'(addr & 255), ack);         ok &= (ack == 1'b0);
    endtask

    task automatic do_write(input int addr, input logic [7:0] d[$], input string tag,
                            input bit wait_done);
        bit ok = 1'b1;
        logic ack;
        int a = addr;
        m_start();
        send_addr(addr, ok);
        foreach (d[i]) begin
            wbyte_lsb(d[i], ack);
            ok &= (ack == 1'b0);
            if ((a >> 1) != (IDA >> 1)) bm[a % DEPTH] = d[i];
            bcur = (a + 1) % DEPTH;
            a = (a & ~127) | ((a + 1) & 127);
        end
        m_stop();
        chk(ok, {tag, " write acks"}, int'(ok), 1);
        if (wait_done) wt(WRC + 40);
    endtask

    task automatic read_run(input int n, input string tag);
        logic [7:0] v;
        logic [7:0] e;
        for (int i = 0; i < n; i++) begin
            e = exp_rd(bcur);
            rbyte_lsb(i != n - 1, v);
            chk(v == e, {tag, " read byte"}, int'(v), int'(e));
            bcur = nxt_rd(bcur);
        end
        m_stop();
    endtask

    task automatic do_rread(input int addr, input int n, input string tag);
        bit ok = 1'b1;
        logic ack;
        m_start();
        send_addr(addr, ok);
        m_start();
        wbyte_msb(8'hA7, ack);
        ok &= (ack == 1'b0);
        chk(ok, {tag, " random read acks"}, int'(ok), 1);
        bcur = addr;
        read_run(n, tag);
    endtask

    task automatic do_cread(input int n, input string tag);
        logic ack;
        m_start();
        wbyte_msb(8'hA7, ack);
        chk(ack == 1'b0, {tag, " current read ack"}, int'(ack), 0);
        read_run(n, tag);
    endtask

    initial begin
        logic ack;
        bit ok;
        for (int i = 0; i < DEPTH; i++) bm[i] = 8'h00;
        wt(5);
        rst = 1'b0;
        wt(5);

        // R10: released after reset
        chk(sda_oe == 1'b0 && sda_line == 1'b1, "R10 reset release", int'(sda_oe), 0);

        // R1: foreign device address, write and read direction
        m_start(); wbyte_msb(8'hA4, ack); m_stop();
        chk(ack == 1'b1, "R1 wrong address nack", int'(ack), 1);
        m_start(); wbyte_msb(8'hE7, ack); m_stop();
        chk(ack == 1'b1, "R1 wrong address read nack", int'(ack), 1);

        // R2 R3: write three bytes, read back
        do_write('h000005, '{8'h01, 8'hC4, 8'h5A}, "R2", 1'b1);
        do_rread('h000005, 3, "R3");

        // R5: page wrap on write
        do_write('h00007E, '{8'h11, 8'h22, 8'h33, 8'h44}, "R5", 1'b1);
        do_rread('h00007E, 4, "R5");
        do_rread('h000000, 2, "R5");

        // R6 R7: write cycle busy, then next-page current address
        do_write('h000100, '{8'hA5}, "R7", 1'b1);
        do_write('h0000FF, '{8'h3C}, "R6", 1'b0);
        m_start(); wbyte_msb(8'hA6, ack); m_stop();
        chk(ack == 1'b1, "R6 busy nack", int'(ack), 1);
        wt(WRC + 40);
        do_cread(1, "R7");

        // R9: identification bytes, write ignored
        do_rread(IDA, 2, "R9");
        do_write(IDA, '{8'h55}, "R9", 1'b1);
        do_rread(IDA, 2, "R9");
        do_rread('h000000, 1, "R9");

        // R8: sequential read across end of array, then continue
        do_write(DEPTH - 2, '{8'hE1, 8'hE2}, "R8", 1'b1);
        do_rread(DEPTH - 2, 5, "R8");
        do_cread(2, "R8");

        // R11: address-only write sets address, starts no write cycle
        ok = 1'b1;
        m_start(); send_addr('h000100, ok); m_stop();
        chk(ok, "R11 address acks", int'(ok), 1);
        bcur = 'h000100;
        m_start(); wbyte_msb(8'hA6, ack); m_stop();
        chk(ack == 1'b0, "R11 no busy", int'(ack), 0);
        do_cread(1, "R11");

        // R4: start in the middle of an address byte
        ok = 1'b1;
        m_start();
        wbyte_msb(8'hA6, ack);
        ok &= (ack == 1'b0);
        for (int i = 0; i < 4; i++) m_wbit(1'b1);
        chk(ok, "R4 device ack", int'(ok), 1);
        do_cread(1, "R4");

        // R10: no drive outside slave bits at any clock
        chk(drive_viol == 0, "R10 drive window", drive_viol, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule